// File: doc/BRIEF.md
# Device Operating Mode Controller

This block holds the chip's current operating mode and moves it between eight modes: RESET, TEST, SAFE, DRUN and RUN0 to RUN3. Software asks for a new mode by writing a 4-bit mode code with a one-cycle write strobe. A reset-generation unit can force a move at any time. Its system reset request forces RESET, and its recoverable-failure request forces SAFE. Each target mode accepts only a fixed set of source modes. Hardware requests win over software writes.

Entering RESET takes effect on the next clock edge and has no settling phase. The controller stays in RESET until the reset-sequence-done input is seen. It then starts the move to DRUN without any software write. Every other move passes through a pending phase of `SETTLE` cycles, which stands for clock and power settling. The current-mode output changes only when that phase ends, and only one move can be pending at a time. The block also reports the kind of the last reset (functional or destructive), a flag that selects the internal RC oscillator as the system clock, and a one-cycle flag for rejected writes.

Internally a state machine has three states. ST_RESET is the held reset. ST_STABLE means a mode is in force. ST_PENDING means a move is settling. It takes five actions: ACT_HARD_RST (system reset request), ACT_RST_FUNC and ACT_RST_DEST (software reset writes), ACT_MOVE (a settled move: reset exit, safe request or software write) and ACT_NONE. In ST_PENDING with ACT_NONE, the timer's expiry completes the move.

Top module: `opmode_ctrl`

## Requirements
- R1: After `rst_n` is released, the outputs are as follows: `cur_mode` = 4'b0000, `pending` = 0, `reset_kind` = 1, `sysclk_irc` = 1 and `bad_req` = 0.
- R2: `cur_mode` encodes the modes as RESET 4'b0000, TEST 4'b0001, SAFE 4'b0010, DRUN 4'b0011 and RUN0..RUN3 4'b0100..4'b0111. A write names its target with the same codes.
- R3: A write of 4'b0000 (functional) or 4'b1111 (destructive) is honoured from any mode other than RESET while nothing is pending. After the next edge, `cur_mode` = 4'b0000, `pending` = 0, `sysclk_irc` = 1, and `reset_kind` = 0 for a functional reset or 1 for a destructive one.
- R4: `sys_rst_req` high at an edge forces `cur_mode` = 4'b0000, `pending` = 0, `reset_kind` = 1 and `sysclk_irc` = 1 after that edge. This holds from every state, and the request overrides every other input.
- R5: RESET holds until `seq_done` is sampled high with no `sys_rst_req`. After that edge `pending` rises with DRUN as the target, without any write.
- R6: Every move that is not a reset keeps `pending` high for exactly `SETTLE` cycles, starting after the accepting edge. `cur_mode` keeps its old value during those cycles and takes the target value in the cycle in which `pending` falls.
- R7: A write of DRUN is legal from SAFE, TEST or any RUN mode. A write of SAFE is legal from DRUN, TEST or any RUN mode. A write of TEST is legal only from DRUN. A write of RUNn is legal from DRUN or from a RUN mode other than RUNn.
- R8: A write is rejected, and leaves the mode state unchanged, in any of these cases: its code is illegal from the current mode; the code is undefined (4'b1000 to 4'b1110); it arrives in RESET or while a move is pending; or it coincides with `sys_rst_req` or `safe_req`. `bad_req` is high for the one cycle after each rejected write.
- R9: `safe_req` starts a move to SAFE when `cur_mode` is neither RESET nor SAFE. It also replaces a pending move whose target is not SAFE, and the timer restarts. It is ignored while `cur_mode` is RESET, including the settling phase of the reset exit.
- R10: `sysclk_irc` is 1 in RESET and in a DRUN entered from RESET. It becomes 0 when any other move completes, and it keeps its value while a move is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mctl_wr | input | 1 | One-cycle strobe for a mode write |
| mctl_code | input | 4 | Requested mode code, valid with `mctl_wr` |
| seq_done | input | 1 | Reset sequence has completed |
| sys_rst_req | input | 1 | Non-recoverable failure reset request |
| safe_req | input | 1 | Recoverable failure request for SAFE |
| cur_mode | output | 4 | Current mode code |
| pending | output | 1 | A settling move is in progress |
| reset_kind | output | 1 | Kind of the last reset: 0 functional, 1 destructive |
| sysclk_irc | output | 1 | 1 selects the internal RC oscillator as system clock |
| bad_req | output | 1 | Previous cycle held a rejected write |

## Verification
The properties assume that every input is synchronous to `clk` and stable across each rising edge. They also assume that `mctl_code` matters only when `mctl_wr` is high, and that `seq_done` has effect only while the controller sits in RESET. The bench keeps to these assumptions by changing every input only just after a falling edge. Its random phase draws hardware requests at low rates, so long settling phases still complete between them. Stray `seq_done` pulses outside RESET exercise the assumption that they have no effect.

// File: rtl/opmode_pkg.sv
package opmode_pkg;

    typedef enum logic [3:0] {
        MD_RESET = 4'h0,
        MD_TEST  = 4'h1,
        MD_SAFE  = 4'h2,
        MD_DRUN  = 4'h3,
        MD_RUN0  = 4'h4,
        MD_RUN1  = 4'h5,
        MD_RUN2  = 4'h6,
        MD_RUN3  = 4'h7
    } mode_e;

    localparam logic [3:0] CODE_RST_FUNC = 4'h0;
    localparam logic [3:0] CODE_RST_DEST = 4'hF;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_HARD_RST,
        ACT_RST_FUNC,
        ACT_RST_DEST,
        ACT_MOVE
    } act_e;

    typedef enum logic [1:0] {
        ST_RESET,
        ST_STABLE,
        ST_PENDING
    } ctl_state_e;

    function automatic logic is_run(input logic [3:0] m);
        return m[3:2] == 2'b01;
    endfunction

    // Source-mode legality of a software write
    function automatic logic sw_legal(input logic [3:0] cur, input logic [3:0] code);
        logic ok;
        ok = 1'b0;
        case (code)
            CODE_RST_FUNC, CODE_RST_DEST: ok = (cur != MD_RESET);
            MD_DRUN: ok = is_run(cur) || cur == MD_SAFE || cur == MD_TEST;
            MD_SAFE: ok = is_run(cur) || cur == MD_DRUN || cur == MD_TEST;
            MD_TEST: ok = (cur == MD_DRUN);
            MD_RUN0, MD_RUN1, MD_RUN2, MD_RUN3:
                ok = (cur == MD_DRUN || is_run(cur)) && cur != code;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/opmode_settle.sv
module opmode_settle #(
    parameter int SETTLE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(SETTLE + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
        end else if (run && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/opmode_arbiter.sv
module opmode_arbiter
    import opmode_pkg::*;
(
    input  ctl_state_e  state,
    input  logic [3:0]  cur_mode,
    input  logic [3:0]  tgt_mode,
    input  logic        wr,
    input  logic [3:0]  code,
    input  logic        seq_done,
    input  logic        sys_rst,
    input  logic        safe_req,
    output act_e        act,
    output logic [3:0]  act_tgt,
    output logic        wr_reject
);
    logic sw_take;
    logic safe_go;

    assign safe_go = safe_req && cur_mode != MD_RESET &&
                     ((state == ST_STABLE  && cur_mode != MD_SAFE) ||
                      (state == ST_PENDING && tgt_mode != MD_SAFE));

    always_comb begin
        act     = ACT_NONE;
        act_tgt = tgt_mode;
        sw_take = 1'b0;
        if (sys_rst) begin
            act = ACT_HARD_RST;
        end else if (state == ST_RESET) begin
            if (seq_done) begin
                act     = ACT_MOVE;
                act_tgt = MD_DRUN;
            end
        end else if (safe_go) begin
            act     = ACT_MOVE;
            act_tgt = MD_SAFE;
        end else if (wr && !safe_req && state == ST_STABLE && sw_legal(cur_mode, code)) begin
            sw_take = 1'b1;
            if (code == CODE_RST_FUNC) begin
                act = ACT_RST_FUNC;
            end else if (code == CODE_RST_DEST) begin
                act = ACT_RST_DEST;
            end else begin
                act     = ACT_MOVE;
                act_tgt = code;
            end
        end
        wr_reject = wr && !sw_take;
    end
endmodule

// File: rtl/opmode_ctrl.sv
module opmode_ctrl
    import opmode_pkg::*;
#(
    parameter int SETTLE = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mctl_wr,
    input  logic [3:0] mctl_code,
    input  logic       seq_done,
    input  logic       sys_rst_req,
    input  logic       safe_req,
    output logic [3:0] cur_mode,
    output logic       pending,
    output logic       reset_kind,
    output logic       sysclk_irc,
    output logic       bad_req
);
    ctl_state_e state_q, state_d;
    logic [3:0] mode_q, mode_d, tgt_q, tgt_d;
    logic       kind_q, kind_d, irc_q, irc_d, bad_q, bad_d;
    act_e       act;
    logic [3:0] act_tgt;
    logic       wr_reject, tmr_start, tmr_done;

    opmode_arbiter u_arb (
        .state     (state_q),
        .cur_mode  (mode_q),
        .tgt_mode  (tgt_q),
        .wr        (mctl_wr),
        .code      (mctl_code),
        .seq_done  (seq_done),
        .sys_rst   (sys_rst_req),
        .safe_req  (safe_req),
        .act       (act),
        .act_tgt   (act_tgt),
        .wr_reject (wr_reject)
    );

    opmode_settle #(.SETTLE(SETTLE)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .run   (state_q == ST_PENDING),
        .done  (tmr_done)
    );

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        mode_d    = mode_q;
        tgt_d     = tgt_q;
        kind_d    = kind_q;
        irc_d     = irc_q;
        bad_d     = wr_reject;
        tmr_start = 1'b0;
        unique case (act)
            ACT_HARD_RST, ACT_RST_DEST, ACT_RST_FUNC: begin
                state_d = ST_RESET;
                mode_d  = MD_RESET;
                kind_d  = (act != ACT_RST_FUNC);
                irc_d   = 1'b1;
            end
            ACT_MOVE: begin
                state_d   = ST_PENDING;
                tgt_d     = act_tgt;
                tmr_start = 1'b1;
            end
            ACT_NONE: begin
                if (state_q == ST_PENDING && tmr_done) begin
                    state_d = ST_STABLE;
                    mode_d  = tgt_q;
                    irc_d   = (mode_q == MD_RESET);
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
            mode_q  <= MD_RESET;
            tgt_q   <= MD_RESET;
            kind_q  <= 1'b1;
            irc_q   <= 1'b1;
            bad_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            tgt_q   <= tgt_d;
            kind_q  <= kind_d;
            irc_q   <= irc_d;
            bad_q   <= bad_d;
        end
    end

    // Outputs
    always_comb begin
        cur_mode   = mode_q;
        pending    = (state_q == ST_PENDING);
        reset_kind = kind_q;
        sysclk_irc = irc_q;
        bad_req    = bad_q;
    end
endmodule

// File: rtl/opmode_ctrl_chk.sv
module opmode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mctl_wr,
    input logic [3:0] mctl_code,
    input logic       seq_done,
    input logic       sys_rst_req,
    input logic       safe_req,
    input logic [3:0] cur_mode,
    input logic       pending,
    input logic       reset_kind,
    input logic       sysclk_irc,
    input logic       bad_req
);
    a_r4_sys_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> (cur_mode == 4'h0 && !pending && reset_kind && sysclk_irc));

    a_r3_dest_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mctl_wr && mctl_code == 4'hF && !sys_rst_req && !safe_req && !pending && cur_mode != 4'h0)
        |=> (cur_mode == 4'h0 && !pending && reset_kind));

    a_r5_reset_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 4'h0 && !pending && !seq_done) |=> (cur_mode == 4'h0 && !pending));

    a_r6_mode_moves_on_settle: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_mode) |-> (cur_mode == 4'h0 || $fell(pending)));

    a_r8_undefined_code: assert property (@(posedge clk) disable iff (!rst_n)
        (mctl_wr && mctl_code >= 4'h8 && mctl_code <= 4'hE) |=> bad_req);

    a_r9_safe_request: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_req && !sys_rst_req && cur_mode != 4'h0) |=> (pending || cur_mode == 4'h2));

    a_r10_irc_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 4'h0) |-> sysclk_irc);
endmodule

bind opmode_ctrl opmode_ctrl_chk i_opmode_ctrl_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mctl_wr     (mctl_wr),
    .mctl_code   (mctl_code),
    .seq_done    (seq_done),
    .sys_rst_req (sys_rst_req),
    .safe_req    (safe_req),
    .cur_mode    (cur_mode),
    .pending     (pending),
    .reset_kind  (reset_kind),
    .sysclk_irc  (sysclk_irc),
    .bad_req     (bad_req)
);

// File: tb/test_opmode_ctrl.sv
`timescale 1ns/1ps
module test_opmode_ctrl;
    localparam int SETTLE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       d_wr = 1'b0;
    logic [3:0] d_code = 4'h0;
    logic       d_seq = 1'b0;
    logic       d_sys = 1'b0;
    logic       d_safe = 1'b0;
    logic [3:0] cur_mode;
    logic       pending, reset_kind, sysclk_irc, bad_req;

    int checks = 0;
    int failures = 0;
    bit armed = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    opmode_ctrl #(.SETTLE(SETTLE)) i_opmode_ctrl (
        .clk(clk), .rst_n(rst_n), .mctl_wr(d_wr), .mctl_code(d_code),
        .seq_done(d_seq), .sys_rst_req(d_sys), .safe_req(d_safe),
        .cur_mode(cur_mode), .pending(pending), .reset_kind(reset_kind),
        .sysclk_irc(sysclk_irc), .bad_req(bad_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // R7: legal source modes per target code (R2 codes)
    function automatic bit legal(input int cur, input int code);
        bit run_c;
        run_c = (cur >= 4 && cur <= 7);
        if (cur == 0) return 0;
        if (code == 0 || code == 15) return 1;
        if (code == 3) return run_c || cur == 2 || cur == 1;
        if (code == 2) return run_c || cur == 3 || cur == 1;
        if (code == 1) return cur == 3;
        if (code >= 4 && code <= 7) return (cur == 3 || run_c) && cur != code;
        return 0;
    endfunction

    // Behavioural reference model
    int m_mode = 0, m_tgt = 0, m_cnt = 0;
    bit m_pend = 0, m_kind = 1, m_irc = 1, m_bad = 0;

    always @(posedge clk) begin
        bit took;
        took = 0;
        if (!rst_n) begin
            m_mode = 0; m_pend = 0; m_cnt = 0; m_tgt = 0;
            m_kind = 1; m_irc = 1; m_bad = 0;
        end else begin
            if (d_sys) begin
                m_mode = 0; m_pend = 0; m_kind = 1; m_irc = 1;
            end else if (m_mode == 0 && !m_pend) begin
                if (d_seq) begin m_pend = 1; m_cnt = SETTLE; m_tgt = 3; end
            end else if (d_safe && m_mode != 0 && (m_pend ? (m_tgt != 2) : (m_mode != 2))) begin
                m_pend = 1; m_cnt = SETTLE; m_tgt = 2;
            end else if (d_wr && !d_safe && !m_pend && legal(m_mode, int'(d_code))) begin
                took = 1;
                if (d_code == 4'h0 || d_code == 4'hF) begin
                    m_mode = 0; m_kind = (d_code == 4'hF); m_irc = 1;
                end else begin
                    m_pend = 1; m_cnt = SETTLE; m_tgt = int'(d_code);
                end
            end else if (m_pend) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_irc = (m_mode == 0); m_mode = m_tgt; m_pend = 0;
                end
            end
            m_bad = d_wr && !took;
        end
    end

    always @(negedge clk) begin
        if (armed && !finished) begin
            chk("R2 cur_mode vs model", int'(cur_mode), m_mode);
            chk("R6 pending vs model", int'(pending), int'(m_pend));
            chk("R3 reset_kind vs model", int'(reset_kind), int'(m_kind));
            chk("R10 sysclk_irc vs model", int'(sysclk_irc), int'(m_irc));
            chk("R8 bad_req vs model", int'(bad_req), int'(m_bad));
        end
    end

    task automatic step(input bit wr, input int code, input bit seq, input bit sys, input bit safe);
        d_wr = wr; d_code = 4'(code); d_seq = seq; d_sys = sys; d_safe = safe;
        @(negedge clk);
        d_wr = 0; d_seq = 0; d_sys = 0; d_safe = 0;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0);
    endtask

    // n edges until completion; R6 pending holds, then mode updates
    task automatic settle(input int n, input int exp_mode, input string tag);
        for (int i = 0; i < n - 1; i++) begin
            idle();
            chk({tag, " R6 still pending"}, int'(pending), 1);
        end
        idle();
        chk({tag, " R6 pending fell"}, int'(pending), 0);
        chk({tag, " R6 mode reached"}, int'(cur_mode), exp_mode);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        armed = 1;
        // R1 reset state
        chk("R1 mode", int'(cur_mode), 0);
        chk("R1 pending", int'(pending), 0);
        chk("R1 kind", int'(reset_kind), 1);
        chk("R1 irc", int'(sysclk_irc), 1);
        chk("R1 bad", int'(bad_req), 0);
        idle(); idle();
        chk("R5 reset sticky", int'(cur_mode), 0);
        // R5 automatic exit to DRUN
        step(0, 0, 1, 0, 0);
        chk("R5 pending after seq_done", int'(pending), 1);
        chk("R5 mode held", int'(cur_mode), 0);
        settle(SETTLE, 3, "R5");
        chk("R10 irc in DRUN from reset", int'(sysclk_irc), 1);
        // R7 DRUN -> RUN2
        step(1, 6, 0, 0, 0);
        chk("R7 run2 accepted", int'(pending), 1);
        settle(SETTLE, 6, "R7");
        chk("R10 irc after move", int'(sysclk_irc), 0);
        // R8 illegal TEST from RUN2
        step(1, 1, 0, 0, 0);
        chk("R8 bad after illegal", int'(bad_req), 1);
        chk("R8 mode unchanged", int'(cur_mode), 6);
        chk("R8 no pending", int'(pending), 0);
        idle();
        chk("R8 bad one cycle", int'(bad_req), 0);
        step(1, 10, 0, 0, 0);
        chk("R8 undefined code", int'(bad_req), 1);
        step(1, 6, 0, 0, 0);
        chk("R8 same mode rejected", int'(bad_req), 1);
        // R9 safe request
        step(0, 0, 0, 0, 1);
        chk("R9 safe pending", int'(pending), 1);
        settle(SETTLE, 2, "R9");
        // R7 SAFE -> DRUN, R10 irc stays 0
        step(1, 3, 0, 0, 0);
        settle(SETTLE, 3, "R7");
        chk("R10 irc DRUN not from reset", int'(sysclk_irc), 0);
        // R7 DRUN -> TEST, R8 write during pending
        step(1, 1, 0, 0, 0);
        step(1, 4, 0, 0, 0);
        chk("R8 write while pending", int'(bad_req), 1);
        settle(SETTLE - 1, 1, "R7");
        // R3 destructive write
        step(1, 15, 0, 0, 0);
        chk("R3 dest mode", int'(cur_mode), 0);
        chk("R3 dest kind", int'(reset_kind), 1);
        chk("R3 dest no pending", int'(pending), 0);
        step(1, 3, 0, 0, 0);
        chk("R8 write in reset", int'(bad_req), 1);
        step(0, 0, 0, 0, 1);
        chk("R9 safe ignored in reset", int'(pending), 0);
        step(0, 0, 1, 0, 0);
        settle(SETTLE, 3, "R5");
        // R3 functional write
        step(1, 0, 0, 0, 0);
        chk("R3 func mode", int'(cur_mode), 0);
        chk("R3 func kind", int'(reset_kind), 0);
        // R9 safe ignored during reset exit
        step(0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1);
        chk("R9 reset exit keeps going", int'(pending), 1);
        settle(SETTLE - 1, 3, "R9");
        // R4 system reset during pending
        step(1, 5, 0, 0, 0);
        step(0, 0, 0, 1, 0);
        chk("R4 mode", int'(cur_mode), 0);
        chk("R4 pending", int'(pending), 0);
        chk("R4 kind", int'(reset_kind), 1);
        step(0, 0, 1, 1, 0);
        chk("R4 overrides seq_done", int'(pending), 0);
        // Mixed phase against the model
        for (int i = 0; i < 6000; i++) begin
            int r;
            int c;
            r = int'($urandom % 100);
            c = (r < 50) ? int'($urandom % 8) : int'($urandom % 16);
            step(($urandom % 3) == 0, c, ($urandom % 6) == 0,
                 ($urandom % 97) == 0, ($urandom % 41) == 0);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule